// File: doc/BRIEF.md
# Prefix-Tagged Halfword Instruction Assembler

This block takes one instruction block: a run of 16-bit halfwords plus a 3-bit tag for each of them. The tags come from a header that sits ahead of the halfwords. The block decides, for every halfword, whether an instruction starts there. It also decides which kind of instruction it is, and it builds the full instruction word. Some instruction kinds are longer than the halfwords they occupy. Their extra leading or middle bits are carried in the tags and are spliced onto the halfword data as the word is built.

A mode input selects between two tag tables. The default table has the following kinds:
- 17-bit short instructions.
- 32-bit instructions.
- A second 32-bit instruction set.
- 35-bit memory-reference instructions.

The alternate table has these kinds instead:
- 18-bit short instructions.
- 33-bit memory-reference instructions.
- Plain 32-bit instructions.

Every halfword is decoded at the same time from its own tag and its successor's tag and data. One registered result is produced per accepted block, one cycle after it is presented. Execution and operand fetch belong to later stages.

Top module: `pfx_insn_asm`

## Requirements
- R1: While `rst` is high at a clock edge, the following outputs are cleared to zero after that edge: `out_valid`, `start_flags`, `err_flags`, `class_bus` and `word_bus`.
- R2: A block presented with `in_valid` high appears on the outputs after the next clock edge, and `out_valid` is high for that one cycle. With `in_valid` low, `out_valid` is low and all result outputs keep their values.
- R3: In default mode (`r_mode`=0), tag 000 or 001 gives class 1 (17-bit short) with a start flag. The word is {tag bit 0, halfword}, placed in bits 16:0 with zeros above.
- R4: In default mode, tag 010 gives a start flag and the word {halfword, next halfword}, placed in bits 31:0. The class is 3 (second 32-bit set) when the next tag is 111. Otherwise the class is 2 (32-bit or longer).
- R5: In default mode, tags 100, 101 and 110 give class 4 (35-bit) with a start flag. The word is {tag bits 1:0, halfword, m, next halfword} in bits 34:0. Here m is 1 exactly when the next tag is 111.
- R6: A class-4 start raises its error flag when the next tag is neither 011 nor 111, or when it is the last halfword. No other default-mode case raises an error flag.
- R7: Tag 011 in either mode, and tag 111 in default mode, produce no start flag, class 0, a zero word and no error.
- R8: In R mode (`r_mode`=1), tag 000 or 001 gives class 6 (33-bit) with a start flag. The word is {tag bit 0, halfword, next halfword} in bits 32:0.
- R9: In R mode, tags 100 to 111 give class 5 (18-bit short) with a start flag. The word is {tag bits 1:0, halfword} in bits 17:0.
- R10: In R mode, tag 010 gives a start flag and the word {halfword, next halfword}. The class is 7 (illegal), with the error flag set, when the next tag is 111. Otherwise the class is 2. Class 3 never appears in R mode.
- R11: For the last halfword, the missing successor reads as data zero and as a tag that is neither 011 nor 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block on the inputs is to be decoded |
| r_mode | input | 1 | Selects the alternate tag table (18/33-bit kinds) |
| tag_bus | input | NHW*3 | Tag of halfword i in bits 3i+2:3i |
| hw_bus | input | NHW*HW_W | Halfword i in bits HW_W*(i+1)-1:HW_W*i |
| out_valid | output | 1 | Results below belong to a newly accepted block |
| start_flags | output | NHW | Bit i high when an instruction starts at halfword i |
| err_flags | output | NHW | Bit i high when halfword i starts a malformed sequence |
| class_bus | output | NHW*3 | Class code of halfword i in bits 3i+2:3i |
| word_bus | output | NHW*(2*HW_W+3) | Assembled word of halfword i, right-aligned in its field |

## Verification
Each halfword's decode is a pure function of its own tag and its successor's tag and data. A wrong tag-table entry or a wrong splice order therefore shows up in the first result after the offending block, one cycle after it is presented, in that halfword's class or word field. A mix-up between neighbours, such as reading the wrong successor or mishandling the last halfword, shows up only for particular tag pairs. That is why the sweep drives every tag combination of a small block in both modes. A capture-enable or valid-timing fault shows up as a changed output in an idle cycle or as a missing `out_valid` pulse.

// File: rtl/pfx_asm_pkg.sv
package pfx_asm_pkg;

  localparam int TAG_W = 3;

  typedef enum logic [2:0] {
    CL_NONE    = 3'd0,
    CL_SHORT17 = 3'd1,
    CL_LONG32  = 3'd2,
    CL_ALT32   = 3'd3,
    CL_MEM35   = 3'd4,
    CL_SHORT18 = 3'd5,
    CL_MEM33   = 3'd6,
    CL_ILLEGAL = 3'd7
  } insn_class_t;

  localparam logic [2:0] TAG_CONT  = 3'b011;
  localparam logic [2:0] TAG_SECND = 3'b111;
  localparam logic [2:0] TAG_WIDE  = 3'b010;

endpackage

// File: rtl/pfx_slot_decode.sv
module pfx_slot_decode
  import pfx_asm_pkg::*;
#(
  parameter int HW_W = 16,
  localparam int WORD_W = 2 * HW_W + 3
) (
  input  logic              r_mode,
  input  logic [TAG_W-1:0]  tag,
  input  logic [HW_W-1:0]   hw,
  input  logic              has_next,
  input  logic [TAG_W-1:0]  nxt_tag,
  input  logic [HW_W-1:0]   nxt_hw,
  output logic              start,
  output insn_class_t       cls,
  output logic [WORD_W-1:0] word,
  output logic              err
);

  logic [HW_W-1:0] low_hw;
  logic            nxt_second;
  logic            nxt_cont;

  assign low_hw     = has_next ? nxt_hw : '0;
  assign nxt_second = has_next && (nxt_tag == TAG_SECND);
  assign nxt_cont   = has_next && (nxt_tag == TAG_CONT);

  always_comb begin
    start = 1'b0;
    cls   = CL_NONE;
    word  = '0;
    err   = 1'b0;
    if (!r_mode) begin
      unique case (tag)
        3'b000, 3'b001: begin
          start          = 1'b1;
          cls            = CL_SHORT17;
          word[HW_W:0]   = {tag[0], hw};
        end
        TAG_WIDE: begin
          start             = 1'b1;
          cls               = nxt_second ? CL_ALT32 : CL_LONG32;
          word[2*HW_W-1:0]  = {hw, low_hw};
        end
        3'b100, 3'b101, 3'b110: begin
          start = 1'b1;
          cls   = CL_MEM35;
          word  = {tag[1:0], hw, nxt_second, low_hw};
          err   = !(nxt_second || nxt_cont);
        end
        default: begin
          start = 1'b0;
        end
      endcase
    end else begin
      unique case (tag)
        3'b000, 3'b001: begin
          start           = 1'b1;
          cls             = CL_MEM33;
          word[2*HW_W:0]  = {tag[0], hw, low_hw};
        end
        TAG_WIDE: begin
          start             = 1'b1;
          cls               = nxt_second ? CL_ILLEGAL : CL_LONG32;
          word[2*HW_W-1:0]  = {hw, low_hw};
          err               = nxt_second;
        end
        TAG_CONT: begin
          start = 1'b0;
        end
        default: begin
          start            = 1'b1;
          cls              = CL_SHORT18;
          word[HW_W+1:0]   = {tag[1:0], hw};
        end
      endcase
    end
  end

endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage #(
  parameter int NHW    = 14,
  parameter int WORD_W = 35,
  localparam int CLS_BITS  = NHW * 3,
  localparam int WORD_BITS = NHW * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NHW-1:0]       start_d,
  input  logic [NHW-1:0]       err_d,
  input  logic [CLS_BITS-1:0]  cls_d,
  input  logic [WORD_BITS-1:0] word_d,
  output logic                 valid_q,
  output logic [NHW-1:0]       start_q,
  output logic [NHW-1:0]       err_q,
  output logic [CLS_BITS-1:0]  cls_q,
  output logic [WORD_BITS-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      start_q <= '0;
      err_q   <= '0;
      cls_q   <= '0;
      word_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        start_q <= start_d;
        err_q   <= err_d;
        cls_q   <= cls_d;
        word_q  <= word_d;
      end
    end
  end

endmodule

// File: rtl/pfx_insn_asm.sv
module pfx_insn_asm
  import pfx_asm_pkg::*;
#(
  parameter int NHW  = 14,
  parameter int HW_W = 16,
  localparam int WORD_W = 2 * HW_W + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  r_mode,
  input  logic [NHW*TAG_W-1:0]  tag_bus,
  input  logic [NHW*HW_W-1:0]   hw_bus,
  output logic                  out_valid,
  output logic [NHW-1:0]        start_flags,
  output logic [NHW-1:0]        err_flags,
  output logic [NHW*3-1:0]      class_bus,
  output logic [NHW*WORD_W-1:0] word_bus
);

  logic [NHW-1:0]        start_c;
  logic [NHW-1:0]        err_c;
  logic [NHW*3-1:0]      cls_c;
  logic [NHW*WORD_W-1:0] word_c;

  for (genvar i = 0; i < NHW; i++) begin : g_slot
    logic [TAG_W-1:0] nxt_tag;
    logic [HW_W-1:0]  nxt_hw;
    logic             has_next;
    insn_class_t      cls_i;

    if (i < NHW - 1) begin : g_mid
      assign has_next = 1'b1;
      assign nxt_tag  = tag_bus[(i+1)*TAG_W +: TAG_W];
      assign nxt_hw   = hw_bus[(i+1)*HW_W +: HW_W];
    end else begin : g_last
      assign has_next = 1'b0;
      assign nxt_tag  = '0;
      assign nxt_hw   = '0;
    end

    pfx_slot_decode #(.HW_W(HW_W)) dec_i (
      .r_mode   (r_mode),
      .tag      (tag_bus[i*TAG_W +: TAG_W]),
      .hw       (hw_bus[i*HW_W +: HW_W]),
      .has_next (has_next),
      .nxt_tag  (nxt_tag),
      .nxt_hw   (nxt_hw),
      .start    (start_c[i]),
      .cls      (cls_i),
      .word     (word_c[i*WORD_W +: WORD_W]),
      .err      (err_c[i])
    );

    assign cls_c[i*3 +: 3] = cls_i;
  end

  pfx_out_stage #(.NHW(NHW), .WORD_W(WORD_W)) out_i (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .start_d (start_c),
    .err_d   (err_c),
    .cls_d   (cls_c),
    .word_d  (word_c),
    .valid_q (out_valid),
    .start_q (start_flags),
    .err_q   (err_flags),
    .cls_q   (class_bus),
    .word_q  (word_bus)
  );

endmodule

// File: rtl/pfx_insn_asm_chk.sv
module pfx_insn_asm_chk #(
  parameter int NHW    = 14,
  parameter int WORD_W = 35
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  r_mode,
  input logic                  out_valid,
  input logic [NHW-1:0]        start_flags,
  input logic [NHW-1:0]        err_flags,
  input logic [NHW*3-1:0]      class_bus,
  input logic [NHW*WORD_W-1:0] word_bus
);

  logic err_ok;
  logic start_ok;
  logic no_alt;
  logic idle_zero;

  always_comb begin
    err_ok    = 1'b1;
    start_ok  = 1'b1;
    no_alt    = 1'b1;
    idle_zero = 1'b1;
    for (int i = 0; i < NHW; i++) begin
      if (err_flags[i] && !(class_bus[i*3 +: 3] == 3'd4 || class_bus[i*3 +: 3] == 3'd7))
        err_ok = 1'b0;
      if (start_flags[i] != (class_bus[i*3 +: 3] != 3'd0))
        start_ok = 1'b0;
      if (class_bus[i*3 +: 3] == 3'd3)
        no_alt = 1'b0;
      if (class_bus[i*3 +: 3] == 3'd0 && word_bus[i*WORD_W +: WORD_W] != '0)
        idle_zero = 1'b0;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && start_flags == '0 && err_flags == '0 && class_bus == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(word_bus) && $stable(class_bus) && $stable(err_flags)));

  assert_err_only_mem_or_illegal_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> err_ok);

  assert_nonstart_empty_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (start_ok && idle_zero));

  assert_rmode_no_alt_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && r_mode) |=> no_alt);

endmodule

bind pfx_insn_asm pfx_insn_asm_chk #(.NHW(NHW), .WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .r_mode      (r_mode),
  .out_valid   (out_valid),
  .start_flags (start_flags),
  .err_flags   (err_flags),
  .class_bus   (class_bus),
  .word_bus    (word_bus)
);

// File: tb/pfx_insn_asm_tb_top.sv
`timescale 1ns/1ps
module pfx_insn_asm_tb_top;

  localparam int NHW    = 4;
  localparam int HW_W   = 16;
  localparam int WORD_W = 2 * HW_W + 3;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  in_valid = 1'b0;
  logic                  r_mode = 1'b0;
  logic [NHW*3-1:0]      tag_bus = '0;
  logic [NHW*HW_W-1:0]   hw_bus = '0;
  logic                  out_valid;
  logic [NHW-1:0]        start_flags;
  logic [NHW-1:0]        err_flags;
  logic [NHW*3-1:0]      class_bus;
  logic [NHW*WORD_W-1:0] word_bus;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfx_insn_asm #(.NHW(NHW), .HW_W(HW_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .r_mode(r_mode),
    .tag_bus(tag_bus), .hw_bus(hw_bus), .out_valid(out_valid),
    .start_flags(start_flags), .err_flags(err_flags),
    .class_bus(class_bus), .word_bus(word_bus)
  );

  task automatic model(input bit m, input logic [2:0] t, input logic [15:0] h,
                       input bit hn, input logic [2:0] nt, input logic [15:0] nh,
                       output logic [2:0] c, output logic [34:0] w,
                       output bit e, output bit s, output string tagname);
    logic [15:0] lo;
    bit sec;
    bit cont;
    lo   = hn ? nh : 16'h0;
    sec  = hn && (nt == 3'b111);
    cont = hn && (nt == 3'b011);
    c = 3'd0; w = '0; e = 1'b0; s = 1'b0; tagname = "R7";
    if (!m) begin
      if (t <= 3'd1) begin
        c = 3'd1; s = 1'b1; w = 35'(h) + (35'(t[0]) << 16); tagname = "R3";
      end else if (t == 3'd2) begin
        c = sec ? 3'd3 : 3'd2; s = 1'b1; w = (35'(h) << 16) + 35'(lo); tagname = "R4";
      end else if (t >= 3'd4 && t <= 3'd6) begin
        c = 3'd4; s = 1'b1;
        w = (35'(t[1:0]) << 33) + (35'(h) << 17) + (35'(sec) << 16) + 35'(lo);
        e = !(sec || cont);
        tagname = hn ? "R5/R6" : "R6/R11";
      end
    end else begin
      if (t <= 3'd1) begin
        c = 3'd6; s = 1'b1;
        w = (35'(t[0]) << 32) + (35'(h) << 16) + 35'(lo); tagname = "R8";
      end else if (t == 3'd2) begin
        c = sec ? 3'd7 : 3'd2; s = 1'b1; e = sec;
        w = (35'(h) << 16) + 35'(lo); tagname = "R10";
      end else if (t >= 3'd4) begin
        c = 3'd5; s = 1'b1; w = 35'(h) + (35'(t[1:0]) << 16); tagname = "R9";
      end
    end
  endtask

  task automatic check_slots(input bit m);
    for (int i = 0; i < NHW; i++) begin
      logic [2:0] ec;
      logic [34:0] ew;
      bit ee;
      bit es;
      string tn;
      bit hn;
      hn = (i < NHW - 1);
      model(m, tag_bus[i*3 +: 3], hw_bus[i*HW_W +: HW_W], hn,
            hn ? tag_bus[(i+1)*3 +: 3] : 3'b000,
            hn ? hw_bus[(i+1)*HW_W +: HW_W] : 16'h0, ec, ew, ee, es, tn);
      if (class_bus[i*3 +: 3] !== ec || word_bus[i*WORD_W +: WORD_W] !== ew ||
          err_flags[i] !== ee || start_flags[i] !== es) begin
        fails++;
        $display("FAIL %s mode=%0d slot=%0d tags=%h: got cls=%0d word=%h err=%0d st=%0d exp cls=%0d word=%h err=%0d st=%0d",
                 tn, m, i, tag_bus, class_bus[i*3 +: 3], word_bus[i*WORD_W +: WORD_W],
                 err_flags[i], start_flags[i], ec, ew, ee, es);
      end
    end
  endtask

  initial begin
    logic [NHW*WORD_W-1:0] held_word;
    logic [NHW*3-1:0]      held_cls;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || start_flags !== '0 || err_flags !== '0 ||
        class_bus !== '0 || word_bus !== '0) begin
      fails++;
      $display("FAIL R1 reset: got valid=%0d cls=%h word=%h exp all zero", out_valid, class_bus, word_bus);
    end
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < (1 << (3*NHW)); v++) begin
        @(negedge clk);
        r_mode   = m[0];
        tag_bus  = v[3*NHW-1:0];
        for (int s = 0; s < NHW; s++)
          hw_bus[s*HW_W +: HW_W] = 16'(v * 40503 + s * 4099 + m * 777 + 16'h5a3c);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        vectors++;
        if (out_valid !== 1'b1) begin
          fails++;
          $display("FAIL R2 out_valid after load: got %0d exp 1", out_valid);
        end
        check_slots(m[0]);
        held_word = word_bus;
        held_cls  = class_bus;
        tag_bus   = ~tag_bus;
        hw_bus    = ~hw_bus;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || word_bus !== held_word || class_bus !== held_cls) begin
          fails++;
          $display("FAIL R2 hold while idle: got valid=%0d word=%h exp valid=0 word=%h",
                   out_valid, word_bus, held_word);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule